// File: doc/BRIEF.md
# Mains Edge Qualifier with Lockout

The block takes a slow square wave derived from the 60 Hz mains and turns it into a clean, low-rate timing reference for the rest of the chip. The raw input is often noisy around its edges. A state flop tracks the input through set and clear conditions. Those conditions are gated by a lagged copy of the flop's own value, so every accepted edge starts a lockout window. While the window is open, noise in the opposite direction cannot pull the output back.

The lag comes from a counter in the fast system clock domain. The counter copies the state into the lag register once the state has stayed unchanged for a set number of cycles; for a window of about 1 ms at 50 MHz that number is 50 000. The raw pin first passes through a flop synchronizer. Along with the qualified level, the block gives a single-cycle pulse on each rising edge of that level, which downstream logic can use as a tick.

Top module: `mains_qualifier`

## Requirements
- R1: A synchronous reset clears the qualified output, the lag copy and the rise strobe to 0.
- R2: The raw input is synchronised by SYNC_STAGES flops (default 2). With the lag low and the output low, a rise on the raw input shows on the qualified output SYNC_STAGES+1 clock edges later.
- R3: The qualified output is set when the synchronised input is 1 and the lag copy is 0.
- R4: The qualified output is cleared when the synchronised input is 0 and the lag copy is 1.
- R5: The lag copy takes the output's value HOLD_CYCLES cycles after the output last changed. If the input drops right after an accepted rise, the output therefore stays high for HOLD_CYCLES+1 cycles.
- R6: An input pulse in the opposite direction during the lockout (output differs from the lag copy) has no effect on the output.
- R7: Under input noise the output changes at most once per lockout window.
- R8: `rise_stb` is high for exactly one cycle, in the first cycle in which the output is 1, on every rising edge of the output. It is never high on a falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| mains_raw | input | 1 | Asynchronous mains-derived square input |
| mains_q | output | 1 | Qualified low-rate output level |
| rise_stb | output | 1 | One-cycle pulse on each rise of `mains_q` |

## Verification
Four kinds of input are applied: a single clean step, which measures the synchroniser latency and the exact length of the lockout; short glitches in the opposite direction during a high lockout and during a low lockout, which show whether the lag gating works; a burst that toggles every cycle, which shows whether noise can cause more than one transition per window; and a long clean square wave, which pairs each strobe with a rising edge. A cycle-level scoreboard compares both outputs with a model built from the requirements during all of these.

// File: rtl/mq_pkg.sv
`timescale 1ns/1ps
package mq_pkg;
  // Width of a counter that must hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mq_sync.sv
`timescale 1ns/1ps
module mq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mq_lag.sv
`timescale 1ns/1ps
module mq_lag #(
  parameter int HOLD = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  output logic lag
);
  import mq_pkg::*;
  localparam int CW = cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lag <= 1'b0;
      cnt <= '0;
    end else if (cur == lag) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      lag <= cur;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  lag_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (cur != lag && cnt != LAST) |=> $stable(lag));
  // R5
  lag_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cur == lag) |=> $stable(lag));
  // R5
  lag_take_chk: assert property (@(posedge clk) disable iff (rst)
    (cur != lag && cnt == LAST) |=> (lag == $past(cur)));
endmodule

// File: rtl/mq_gate.sv
`timescale 1ns/1ps
module mq_gate (
  input  logic clk,
  input  logic rst,
  input  logic sin,
  input  logic lag,
  output logic state,
  output logic rise_stb
);
  logic do_set, do_clr;

  assign do_set = sin & ~lag;
  assign do_clr = ~sin & lag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= 1'b0;
      rise_stb <= 1'b0;
    end else begin
      rise_stb <= do_set & ~state;
      if (do_set)      state <= 1'b1;
      else if (do_clr) state <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!state && !rise_stb));
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state) |-> ($past(sin) && !$past(lag)));
  // R4
  fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(state) |-> (!$past(sin) && $past(lag)));
  // R6
  lock_high_chk: assert property (@(posedge clk) disable iff (rst)
    (state && !lag) |=> state);
  // R6
  lock_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!state && lag) |=> !state);
  // R8
  stb_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> (state && !$past(state)));
  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> !rise_stb);
endmodule

// File: rtl/mains_qualifier.sv
`timescale 1ns/1ps
module mains_qualifier #(
  parameter int HOLD_CYCLES = 50000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mains_raw,
  output logic mains_q,
  output logic rise_stb
);
  logic synced;
  logic lagged;

  mq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (mains_raw),
    .dout(synced)
  );

  mq_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .sin     (synced),
    .lag     (lagged),
    .state   (mains_q),
    .rise_stb(rise_stb)
  );

  mq_lag #(.HOLD(HOLD_CYCLES)) u_lag (
    .clk(clk),
    .rst(rst),
    .cur(mains_q),
    .lag(lagged)
  );

  // R7: the output cannot move again before the lag copy has caught up
  once_per_window_chk: assert property (@(posedge clk) disable iff (rst)
    (mains_q != $past(mains_q)) |=> $stable(mains_q));
endmodule

// File: tb/mains_qualifier_tb_top.sv
`timescale 1ns/1ps
module mains_qualifier_tb_top;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  logic q, stb;

  int n_chk = 0;
  int n_fail = 0;
  int q_edges = 0;
  int q_rises = 0;
  int stb_cnt = 0;
  logic prev_q = 1'b0;

  typedef struct packed { logic q; logic s; } exp_t;
  exp_t sbq[$];

  // reference model state
  logic r1, r2, rq, rd, rs, nq, nd, ns;
  int rc, nc;

  always #2.5 clk = ~clk;

  mains_qualifier #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .mains_raw(raw), .mains_q(q), .rise_stb(stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver side of the scoreboard: model from the requirements, pushes expected items
  always @(posedge clk) begin
    if (rst) begin
      r1 = 0; r2 = 0; rq = 0; rd = 0; rs = 0; rc = 0;
    end else begin
      nd = rd;
      if (rq == rd) nc = 0;
      else if (rc == HOLD - 1) begin nd = rq; nc = 0; end
      else nc = rc + 1;
      ns = r2 & ~rd & ~rq;
      nq = rq;
      if (r2 & ~rd) nq = 1'b1;
      else if (~r2 & rd) nq = 1'b0;
      r2 = r1; r1 = raw; rq = nq; rd = nd; rc = nc; rs = ns;
    end
    sbq.push_back('{q: rq, s: rs});
  end

  // monitor: pops expected items and compares, also counts events
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(q === e.q, "R3 R4 R5 R6 scoreboard mains_q", int'(q), int'(e.q));
      chk(stb === e.s, "R8 scoreboard rise_stb", int'(stb), int'(e.s));
    end
    if (q !== prev_q) begin
      q_edges++;
      if (q === 1'b1) q_rises++;
    end
    if (stb === 1'b1) stb_cnt++;
    prev_q = q;
  end

  initial begin
    int hi;
    bit ok;
    repeat (4) @(negedge clk);
    chk(q === 1'b0, "R1 reset mains_q", int'(q), 0);
    chk(stb === 1'b0, "R1 reset rise_stb", int'(stb), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(q === 1'b0, "R1 idle after reset", int'(q), 0);

    // clean step: latency and lockout length
    raw = 1'b1;
    @(negedge clk); chk(q === 1'b0, "R2 edge 1", int'(q), 0);
    @(negedge clk); chk(q === 1'b0, "R2 edge 2", int'(q), 0);
    @(negedge clk); chk(q === 1'b1, "R2 R3 edge 3", int'(q), 1);
    chk(stb === 1'b1, "R8 strobe on rise", int'(stb), 1);
    raw = 1'b0;
    @(negedge clk); chk(stb === 1'b0, "R8 strobe one cycle", int'(stb), 0);
    hi = 2;
    for (int i = 0; i < 200 && q === 1'b1; i++) begin
      @(negedge clk);
      if (q === 1'b1) hi++;
    end
    chk(hi == HOLD + 1, "R5 high time after early drop", hi, HOLD + 1);
    chk(q === 1'b0, "R4 cleared after lag", int'(q), 0);

    // high glitch inside the low lockout
    ok = 1;
    raw = 1'b1;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (q !== 1'b0) ok = 0; end
    raw = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (q !== 1'b0) ok = 0; end
    chk(ok, "R6 high glitch in low lockout", int'(ok), 1);
    repeat (60) @(negedge clk);

    // low glitch inside the high lockout
    raw = 1'b1;
    for (int i = 0; i < 10 && q !== 1'b1; i++) @(negedge clk);
    chk(q === 1'b1, "R3 set for glitch test", int'(q), 1);
    raw = 1'b0;
    ok = 1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (q !== 1'b1) ok = 0; end
    raw = 1'b1;
    for (int i = 0; i < HOLD + 20; i++) begin @(negedge clk); if (q !== 1'b1) ok = 0; end
    chk(ok, "R6 low glitch in high lockout", int'(ok), 1);
    raw = 1'b0;
    repeat (100) @(negedge clk);
    chk(q === 1'b0, "R4 settled low", int'(q), 0);

    // toggling burst
    q_edges = 0;
    for (int i = 0; i < 31; i++) begin raw = ~raw; @(negedge clk); end
    repeat (HOLD + 10) @(negedge clk);
    chk(q_edges == 1, "R7 one change per window under noise", q_edges, 1);
    chk(q === 1'b1, "R7 ends on final level", int'(q), 1);
    raw = 1'b0;
    repeat (100) @(negedge clk);

    // clean square wave
    stb_cnt = 0; q_rises = 0;
    for (int p = 0; p < 4; p++) begin
      raw = 1'b1; repeat (100) @(negedge clk);
      raw = 1'b0; repeat (100) @(negedge clk);
    end
    chk(stb_cnt == 4, "R8 strobes per wave", stb_cnt, 4);
    chk(q_rises == 4, "R8 rises per wave", q_rises, 4);
    chk(q === 1'b0, "R4 wave ends low", int'(q), 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule